// File: doc/BRIEF.md
# Dual-Line Left-Justified Audio Deserializer

This block receives serial audio from two external converter data lines and turns each frame into parallel words. Both lines share one bit clock and one frame clock. These clocks come from one of two serial-port clock pairs: the playback-side pair or the record-side pair. A configuration input picks the pair. Framing is fixed: 24-bit samples, MSB first, left-justified, with no one-bit delay after the frame-clock transition. No other serial-port format setting reaches this block.

All inputs are oversampled in the system clock domain. A rising bit-clock edge takes one data bit from each line. A change of the frame-clock level starts a new half-frame. The block counts bit clocks between rising frame-clock edges and compares the count with the ratios the selected speed mode allows. A frame is presented only while that comparison is clean. Each frame appears on a valid/ready output stream that carries the left and right words of both lines. The stream has one back-pressure rule. While `out_valid` is high and `out_ready` is low, the output words stay frozen. Any frame that completes during that time is discarded, because serial audio cannot be stalled.

Top module: `ljs_deser_top`

## Requirements
- R1: With `clk_sel` = 1 the playback-side pair (`bclk_pb`, `fclk_pb`) clocks the lines; with `clk_sel` = 0 the record-side pair (`bclk_rc`, `fclk_rc`) does. Activity on the unselected pair produces no output.
- R2: Data is taken on rising bit-clock edges. The bit taken on the first rising edge after a frame-clock level change is the MSB of a 24-bit word, and the remaining 23 bits follow MSB first.
- R3: The word captured while the frame clock is high is the left channel, and the word captured while it is low is the right channel. Bit periods after the 24th in a half-frame are ignored.
- R4: The two lines are deserialized independently. Line 0 occupies bits [23:0] of `out_left`/`out_right`, and line 1 occupies bits [47:24].
- R5: `ratio_err` reflects the bit-clock count between consecutive rising frame-clock edges. `speed` 00 (single) allows 64 or 128, 01 (double) allows only 64, and 1x (quad) raises `ratio_err` at all times.
- R6: No frame is presented while `ratio_err` is high, or before a first ratio has been measured.
- R7: After the right word of a frame completes, `out_valid` rises with all four words. The words stay stable until accepted with `out_ready`. Frames that complete while a word is pending are dropped.
- R8: After reset or any change of `clk_sel`, capture starts only at a frame-clock transition, so the first frame after reset or reselection is never presented.
- R9: After reset `out_valid` is low and, for a non-quad `speed`, `ratio_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the bit-clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 1 | 1: playback-side clock pair, 0: record-side pair |
| speed | input | 2 | Speed mode: 00 single, 01 double, 1x quad |
| bclk_pb | input | 1 | Playback-side bit clock |
| fclk_pb | input | 1 | Playback-side frame clock |
| bclk_rc | input | 1 | Record-side bit clock |
| fclk_rc | input | 1 | Record-side frame clock |
| sdin | input | 2 | Serial data, one bit per line |
| ratio_err | output | 1 | Bit-clock ratio not allowed in current speed mode |
| out_valid | output | 1 | Frame words available |
| out_ready | input | 1 | Consumer accepts the frame words |
| out_left | output | 48 | Left words, line 0 in [23:0] |
| out_right | output | 48 | Right words, line 0 in [23:0] |

## Verification
A bit counter that is off by one shows up at the ports within a single frame, as words shifted by one position with a padding bit or a neighbouring bit pulled in. A wrong channel or line assignment also shows up in the first presented frame. A miscounted ratio, or a wrong allowed-ratio table, shows on `ratio_err` at the next rising frame-clock edge, and frames then appear or vanish in the same frame. State left over from before reset or reselection shows as one extra presented frame. A broken hold rule shows as words that change, or `out_valid` that drops, while `out_ready` is low.

// File: rtl/ljs_pkg.sv
package ljs_pkg;
  localparam int SAMPLE_W = 24;
  localparam int LANES    = 2;
  localparam int CNT_W    = 9;
  localparam int RATIO_LO = 64;
  localparam int RATIO_HI = 128;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_QUAD2  = 2'b11
  } speed_e;
endpackage

// File: rtl/ljs_sync.sv
module ljs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ljs_front.sv
module ljs_front
  import ljs_pkg::*;
#(
  parameter int NL = LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_sel,
  input  logic          bclk_pb,
  input  logic          fclk_pb,
  input  logic          bclk_rc,
  input  logic          fclk_rc,
  input  logic [NL-1:0] sdin,
  output logic          bit_stb,
  output logic          lr_lvl,
  output logic [NL-1:0] sd,
  output logic          resync
);
  localparam int NPAIR = 2;

  logic [1:0] pair_raw [NPAIR];
  logic [1:0] pair_syn [NPAIR];
  logic       sel_q;
  logic       bclk_m;
  logic       bclk_prev;

  assign pair_raw[0] = {bclk_rc, fclk_rc};
  assign pair_raw[1] = {bclk_pb, fclk_pb};

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    ljs_sync #(.W(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pair_raw[p]), .q(pair_syn[p])
    );
  end

  ljs_sync #(.W(NL)) u_dsync (.clk(clk), .rst_n(rst_n), .d(sdin), .q(sd));

  assign bclk_m  = clk_sel ? pair_syn[1][1] : pair_syn[0][1];
  assign lr_lvl  = clk_sel ? pair_syn[1][0] : pair_syn[0][0];
  assign resync  = (clk_sel != sel_q);
  assign bit_stb = bclk_m && !bclk_prev && !resync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      bclk_prev <= 1'b1;
    end else begin
      sel_q     <= clk_sel;
      bclk_prev <= bclk_m;
    end
  end
endmodule

// File: rtl/ljs_lane.sv
module ljs_lane #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/ljs_ratio.sv
module ljs_ratio
  import ljs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       bit_stb,
  input  logic       rise,
  input  logic [1:0] speed,
  output logic       ratio_err,
  output logic       ratio_good
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             had_rise;
  logic             meas_vld;
  logic             allowed;
  logic             quad;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt      <= '0;
      last     <= '0;
      had_rise <= 1'b0;
      meas_vld <= 1'b0;
    end else if (bit_stb) begin
      if (rise) begin
        if (had_rise) begin
          last     <= cnt;
          meas_vld <= 1'b1;
        end
        had_rise <= 1'b1;
        cnt      <= CNT_W'(1);
      end else if (cnt != '1) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    quad    = speed[1];
    allowed = (last == CNT_W'(RATIO_LO)) ||
              ((last == CNT_W'(RATIO_HI)) && (speed == SPD_SINGLE));
    ratio_err  = quad || (meas_vld && !allowed);
    ratio_good = meas_vld && !ratio_err;
  end
endmodule

// File: rtl/ljs_deser_top.sv
module ljs_deser_top
  import ljs_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clk_sel,
  input  logic [1:0]                speed,
  input  logic                      bclk_pb,
  input  logic                      fclk_pb,
  input  logic                      bclk_rc,
  input  logic                      fclk_rc,
  input  logic [LANES-1:0]          sdin,
  output logic                      ratio_err,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANES*SAMPLE_W-1:0] out_left,
  output logic [LANES*SAMPLE_W-1:0] out_right
);
  localparam int IDX_W = $clog2(SAMPLE_W + 1);
  localparam int VEC_W = LANES * SAMPLE_W;

  logic             bit_stb, lr_lvl, resync;
  logic [LANES-1:0] sd;
  logic             have_lr, lr_last, aligned;
  logic [IDX_W-1:0] bit_idx;
  logic             lr_edge, lr_rise, shift_en, half_done;
  logic             done_q, done_lvl_q;
  logic             left_ok, ratio_good, emit;
  logic [VEC_W-1:0] words, left_hold;

  ljs_front #(.NL(LANES)) u_front (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel),
    .bclk_pb(bclk_pb), .fclk_pb(fclk_pb),
    .bclk_rc(bclk_rc), .fclk_rc(fclk_rc),
    .sdin(sdin), .bit_stb(bit_stb), .lr_lvl(lr_lvl),
    .sd(sd), .resync(resync)
  );

  assign lr_edge   = bit_stb && have_lr && (lr_lvl != lr_last);
  assign lr_rise   = lr_edge && lr_lvl;
  assign shift_en  = bit_stb && (lr_edge || (aligned && bit_idx < IDX_W'(SAMPLE_W)));
  assign half_done = shift_en && !lr_edge && (bit_idx == IDX_W'(SAMPLE_W - 1));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ljs_lane #(.W(SAMPLE_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
      .din(sd[l]), .word(words[l*SAMPLE_W +: SAMPLE_W])
    );
  end

  ljs_ratio u_ratio (
    .clk(clk), .rst_n(rst_n), .clr(resync), .bit_stb(bit_stb),
    .rise(lr_rise), .speed(speed),
    .ratio_err(ratio_err), .ratio_good(ratio_good)
  );

  // Framing: half-frame start detection and bit position.
  always_ff @(posedge clk) begin
    if (!rst_n || resync) begin
      have_lr    <= 1'b0;
      lr_last    <= 1'b0;
      aligned    <= 1'b0;
      bit_idx    <= '0;
      done_q     <= 1'b0;
      done_lvl_q <= 1'b0;
    end else begin
      done_q     <= half_done;
      done_lvl_q <= lr_lvl;
      if (bit_stb) begin
        have_lr <= 1'b1;
        lr_last <= lr_lvl;
        if (lr_edge) begin
          aligned <= 1'b1;
          bit_idx <= IDX_W'(1);
        end else if (shift_en) begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end

  // Left word holding and pairing with the right word.
  always_ff @(posedge clk) begin
    if (!rst_n || resync) begin
      left_ok   <= 1'b0;
      left_hold <= '0;
    end else if (lr_rise) begin
      left_ok <= 1'b0;
    end else if (done_q && done_lvl_q) begin
      left_ok   <= 1'b1;
      left_hold <= words;
    end
  end

  assign emit = done_q && !done_lvl_q && left_ok && ratio_good;

  // Output stream register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (emit && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_left  <= left_hold;
      out_right <= words;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ljs_deser_chk.sv
module ljs_deser_chk
  import ljs_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      clk_sel,
  input logic [1:0]                speed,
  input logic                      ratio_err,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [LANES*SAMPLE_W-1:0] out_left,
  input logic [LANES*SAMPLE_W-1:0] out_right
);
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

  assert_drop_on_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  assert_no_frame_on_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !$past(ratio_err));

  assert_quad_flagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    speed[1] |-> ratio_err);

  assert_resel_no_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel != $past(clk_sel)) |=> !$rose(out_valid));
endmodule

bind ljs_deser_top ljs_deser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .speed(speed),
  .ratio_err(ratio_err), .out_valid(out_valid), .out_ready(out_ready),
  .out_left(out_left), .out_right(out_right)
);

// File: tb/ljs_deser_top_tb.sv
`timescale 1ns/1ps
module ljs_deser_top_tb_top;
  localparam int W  = 24;
  localparam int HB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_sel = 1'b0;
  logic [1:0]  speed = 2'b00;
  logic        bclk_pb = 1'b0, fclk_pb = 1'b0, bclk_rc = 1'b0, fclk_rc = 1'b0;
  logic [1:0]  sdin = 2'b00;
  logic        ratio_err, out_valid;
  logic        out_ready = 1'b1;
  logic [47:0] out_left, out_right;

  int n_chk = 0, n_bad = 0, hs_cnt = 0;
  logic [47:0] cap_l, cap_r;
  bit done = 0;

  always #2.5 clk = ~clk;

  ljs_deser_top dut_i (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .speed(speed),
    .bclk_pb(bclk_pb), .fclk_pb(fclk_pb), .bclk_rc(bclk_rc), .fclk_rc(fclk_rc),
    .sdin(sdin), .ratio_err(ratio_err), .out_valid(out_valid),
    .out_ready(out_ready), .out_left(out_left), .out_right(out_right)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      hs_cnt = hs_cnt + 1;
      cap_l  = out_left;
      cap_r  = out_right;
    end
  end

  function automatic logic [23:0] pat(int s, int f, int l, int c);
    logic [31:0] x;
    x = s * 32'h045D9F3B + f * 32'h0001F123 + l * 32'h0003C6EF + c * 32'h00009E37 + 32'h00A5A5A5;
    return x[23:0] ^ x[31:8];
  endfunction

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bclk_pb = 0; fclk_pb = 0; bclk_rc = 0; fclk_rc = 0; sdin = 0;
    repeat (4) @(negedge clk);
    hs_cnt = 0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic drive(input bit pb, input bit b, input bit f);
    if (pb) begin bclk_pb = b; fclk_pb = f; end
    else    begin bclk_rc = b; fclk_rc = f; end
  endtask

  task automatic one_bit(input bit pb, input bit f, input logic [1:0] d);
    @(negedge clk);
    drive(pb, 1'b0, f);
    sdin = d;
    repeat (HB) @(negedge clk);
    drive(pb, 1'b1, f);
    repeat (HB - 1) @(negedge clk);
  endtask

  // Lead-in with frame clock low, then frames beginning with a rising frame clock.
  task automatic play(input bit pb, input int ratio, input int frames, input int s);
    for (int k = 0; k < 4; k++) one_bit(pb, 1'b0, 2'b00);
    for (int fr = 0; fr < frames; fr++) begin
      for (int c = 0; c < 2; c++) begin
        for (int k = 0; k < ratio / 2; k++) begin
          logic [1:0] d;
          if (k < W) d = {pat(s, fr, 1, c)[W-1-k], pat(s, fr, 0, c)[W-1-k]};
          else       d = 2'b11;
          one_bit(pb, (c == 0), d);
        end
      end
    end
    repeat (20) @(negedge clk);
  endtask

  function automatic logic [47:0] expw(int s, int fr, int c);
    return {pat(s, fr, 1, c), pat(s, fr, 0, c)};
  endfunction

  task automatic t_reset();
    do_reset();
    check(out_valid == 1'b0, "R9 out_valid after reset", 48'(out_valid), 48'd0);
    check(ratio_err == 1'b0, "R9 ratio_err after reset", 48'(ratio_err), 48'd0);
  endtask

  task automatic t_good(input bit pb, input logic [1:0] spd, input int ratio, input int s, input string tag);
    clk_sel = pb; speed = spd; out_ready = 1'b1;
    do_reset();
    play(pb, ratio, 3, s);
    check(hs_cnt == 2, {tag, " R8 frames presented"}, 48'(hs_cnt), 48'd2);
    check(cap_l == expw(s, 2, 0), {tag, " R2 R3 R4 left words"}, cap_l, expw(s, 2, 0));
    check(cap_r == expw(s, 2, 1), {tag, " R2 R3 R4 right words"}, cap_r, expw(s, 2, 1));
    check(ratio_err == 1'b0, {tag, " R5 ratio accepted"}, 48'(ratio_err), 48'd0);
  endtask

  task automatic t_bad(input logic [1:0] spd, input int ratio, input string tag);
    clk_sel = 1'b0; speed = spd; out_ready = 1'b1;
    do_reset();
    play(1'b0, ratio, 3, 7);
    check(ratio_err == 1'b1, {tag, " R5 ratio flagged"}, 48'(ratio_err), 48'd1);
    check(hs_cnt == 0, {tag, " R6 no frames on error"}, 48'(hs_cnt), 48'd0);
  endtask

  task automatic t_unselected();
    clk_sel = 1'b0; speed = 2'b00; out_ready = 1'b1;
    do_reset();
    play(1'b1, 64, 3, 11);
    check(hs_cnt == 0, "R1 unselected pair ignored", 48'(hs_cnt), 48'd0);
    check(out_valid == 1'b0, "R1 no valid from unselected pair", 48'(out_valid), 48'd0);
  endtask

  task automatic t_backpressure();
    clk_sel = 1'b0; speed = 2'b00; out_ready = 1'b0;
    do_reset();
    play(1'b0, 64, 3, 21);
    check(out_valid == 1'b1, "R7 valid held while stalled", 48'(out_valid), 48'd1);
    check(out_left == expw(21, 1, 0), "R7 held left is first frame", out_left, expw(21, 1, 0));
    check(out_right == expw(21, 1, 1), "R7 held right is first frame", out_right, expw(21, 1, 1));
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(hs_cnt == 1, "R7 one accept after stall", 48'(hs_cnt), 48'd1);
    check(out_valid == 1'b0, "R7 later frame dropped", 48'(out_valid), 48'd0);
  endtask

  task automatic t_reselect();
    clk_sel = 1'b0; speed = 2'b00; out_ready = 1'b1;
    do_reset();
    play(1'b0, 64, 2, 31);
    check(hs_cnt == 1, "R8 record side before reselect", 48'(hs_cnt), 48'd1);
    clk_sel = 1'b1;
    repeat (4) @(negedge clk);
    play(1'b1, 64, 3, 33);
    check(hs_cnt == 3, "R8 first frame after reselect skipped", 48'(hs_cnt), 48'd3);
    check(cap_l == expw(33, 2, 0), "R1 playback side words", cap_l, expw(33, 2, 0));
  endtask

  initial begin : watchdog
    repeat (190000) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_good(1'b0, 2'b00, 64, 3, "single64");
    t_good(1'b1, 2'b00, 128, 5, "single128");
    t_good(1'b0, 2'b01, 64, 9, "double64");
    t_bad(2'b01, 128, "double128");
    t_bad(2'b00, 96, "single96");
    t_bad(2'b10, 64, "quad64");
    t_unselected();
    t_backpressure();
    t_reselect();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule